// File: doc/BRIEF.md
# Loop-Filtered Change-of-Flow Trace Recorder

This block keeps a running history of where a program's flow of control broke away from straight-line execution. Upstream logic decides when a discontinuity occurs and presents one record per cycle: a 2-bit tag saying whether the address is the place a jump left from (source), the place it landed (destination) or an exception entry point (vector), together with an 18-bit address. Each accepted record is written into a circular memory of 64 rows. When the memory is full, the oldest row is overwritten, and a sticky flag notes that this has happened.

Tight delay loops and polling loops would otherwise fill the memory with copies of the same branch source. A filtering mode prevents this. A shadow register keeps the last address written to memory. While filtering is on, a source record whose address equals that shadow value is dropped. Destination and vector records are never dropped, because repeats of those usually point at a fault worth seeing. A debugger arms the recorder, lets it run, and then dumps the rows through a registered read port, using the write pointer and the wrapped flag to find the oldest entry.

Top module: `cof_trace_rec`

## Requirements
- R1: After reset, `wr_ptr_o` is 0, `wrapped_o` is 0, the recorder is disarmed and every row reads back as kind 0, address 0.
- R2: A record is considered only while armed. A record presented in a cycle where `arm_i` or `clear_i` is high is dropped, and `arm_i` alone never moves the pointer.
- R3: Kind codes: 2'b00 source, 2'b01 destination, 2'b10 vector. Code 2'b11 is not a record and is dropped with no effect.
- R4: With `filt_mode_i` = 0, every accepted record is stored. The row at the old `wr_ptr_o` gets kind in bits [19:18] and address in bits [17:0], and the pointer advances by exactly one.
- R5: Every stored address is also copied into the shadow register. With `filt_mode_i` = 1, a source record whose address equals a valid shadow value is dropped, and both the pointer and the shadow value stay unchanged.
- R6: With `filt_mode_i` = 1, destination and vector records are always stored, even when they repeat back to back.
- R7: Arming invalidates the shadow register, so the first source record after an arm is always stored.
- R8: The pointer wraps from 63 to 0 and overwrites the oldest row. `wrapped_o` rises on the first rollover and stays set until a clear.
- R9: `clear_i` sets the pointer to 0, clears `wrapped_o`, disarms the recorder and invalidates the shadow register. The stored rows are kept.
- R10: `rd_kind_o`/`rd_addr_o` show the row selected by `rd_idx_i` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start recording, invalidate shadow register |
| clear_i | input | 1 | Rewind pointer, clear wrapped flag, disarm |
| rec_valid_i | input | 1 | Record strobe |
| rec_kind_i | input | 2 | Record kind (00 source, 01 destination, 10 vector) |
| rec_addr_i | input | 18 | Record address |
| filt_mode_i | input | 1 | 0 = store all, 1 = drop repeated sources |
| rd_idx_i | input | 6 | Row to read |
| rd_kind_o | output | 2 | Kind stored in selected row |
| rd_addr_o | output | 18 | Address stored in selected row |
| wr_ptr_o | output | 6 | Next row to be written |
| wrapped_o | output | 1 | Sticky rollover flag |

## Verification
The assertions check pointer behaviour on every cycle:
- the pointer holds still while the recorder is disarmed, while arming, and for a reserved kind;
- it steps by exactly one for each record in unfiltered mode and for each destination or vector record in filtered mode;
- a clear rewinds the pointer and the flag;
- the wrapped flag rises only on a 63-to-0 step and then stays set.

Whether a repeated source is dropped depends on the history of stored addresses. That, and the actual row contents and their read-back order, are shown only by the bench's scenarios: directed loops in both modes, re-arming, and a long random run that wraps the memory, followed by full dumps compared against a reference model.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    typedef enum logic [1:0] {
        KIND_SRC = 2'b00,
        KIND_DST = 2'b01,
        KIND_VEC = 2'b10,
        KIND_RSV = 2'b11
    } cof_kind_e;

    function automatic logic kind_is_record(input logic [1:0] k);
        return k != KIND_RSV;
    endfunction

endpackage

// File: rtl/cof_shadow_reg.sv
module cof_shadow_reg #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inval_i,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inval_i) begin
            st_d.valid = 1'b0;
        end else if (load_i) begin
            st_d.valid = 1'b1;
            st_d.addr  = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
endmodule

// File: rtl/cof_loop_filter.sv
module cof_loop_filter
    import cof_trace_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          armed_i,
    input  logic          ctl_busy_i,
    input  logic          rec_valid_i,
    input  logic [1:0]    rec_kind_i,
    input  logic [AW-1:0] rec_addr_i,
    input  logic          filt_mode_i,
    input  logic          shadow_valid_i,
    input  logic [AW-1:0] shadow_addr_i,
    output logic          accept_o
);
    logic candidate;
    logic repeat_src;

    always_comb begin
        candidate  = armed_i && !ctl_busy_i && rec_valid_i && kind_is_record(rec_kind_i);
        repeat_src = filt_mode_i && (rec_kind_i == KIND_SRC) &&
                     shadow_valid_i && (rec_addr_i == shadow_addr_i);
        accept_o   = candidate && !repeat_src;
    end
endmodule

// File: rtl/cof_trace_ptr.sv
module cof_trace_ptr #(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          adv_i,
    output logic [PW-1:0] ptr_o,
    output logic          wrapped_o
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          wrapped;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.ptr     = '0;
            st_d.wrapped = 1'b0;
        end else if (adv_i) begin
            if (st_q.ptr == LAST) begin
                st_d.ptr     = '0;
                st_d.wrapped = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o     = st_q.ptr;
    assign wrapped_o = st_q.wrapped;
endmodule

// File: rtl/cof_trace_mem.sv
module cof_trace_mem #(
    parameter int DEPTH = 64,
    parameter int RW    = 20,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [PW-1:0] widx_i,
    input  logic [RW-1:0] wdata_i,
    input  logic [PW-1:0] ridx_i,
    output logic [RW-1:0] rdata_o
);
    logic [RW-1:0] row_d [DEPTH];
    logic [RW-1:0] row_q [DEPTH];
    logic [RW-1:0] rd_d, rd_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_comb begin
            row_d[g] = row_q[g];
            if (we_i && (widx_i == PW'(g))) row_d[g] = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q[g] <= '0;
            else        row_q[g] <= row_d[g];
        end
    end

    always_comb rd_d = row_q[ridx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/cof_trace_rec.sv
module cof_trace_rec #(
    parameter int DEPTH = 64,
    parameter int AW    = 18,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          clear_i,
    input  logic          rec_valid_i,
    input  logic [1:0]    rec_kind_i,
    input  logic [AW-1:0] rec_addr_i,
    input  logic          filt_mode_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [1:0]    rd_kind_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [PW-1:0] wr_ptr_o,
    output logic          wrapped_o
);
    localparam int RW = AW + 2;

    typedef struct packed {
        logic armed;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic          armed_q;
    logic          accept;
    logic          shadow_valid;
    logic [AW-1:0] shadow_addr;
    logic [RW-1:0] rd_row;

    always_comb begin
        ctl_d = ctl_q;
        if (clear_i)    ctl_d.armed = 1'b0;
        else if (arm_i) ctl_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign armed_q = ctl_q.armed;

    cof_loop_filter #(.AW(AW)) u_filter (
        .armed_i       (armed_q),
        .ctl_busy_i    (arm_i | clear_i),
        .rec_valid_i   (rec_valid_i),
        .rec_kind_i    (rec_kind_i),
        .rec_addr_i    (rec_addr_i),
        .filt_mode_i   (filt_mode_i),
        .shadow_valid_i(shadow_valid),
        .shadow_addr_i (shadow_addr),
        .accept_o      (accept)
    );

    cof_shadow_reg #(.AW(AW)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .inval_i(arm_i | clear_i),
        .load_i (accept),
        .addr_i (rec_addr_i),
        .valid_o(shadow_valid),
        .addr_o (shadow_addr)
    );

    cof_trace_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .adv_i    (accept),
        .ptr_o    (wr_ptr_o),
        .wrapped_o(wrapped_o)
    );

    cof_trace_mem #(.DEPTH(DEPTH), .RW(RW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (accept),
        .widx_i (wr_ptr_o),
        .wdata_i({rec_kind_i, rec_addr_i}),
        .ridx_i (rd_idx_i),
        .rdata_o(rd_row)
    );

    assign rd_kind_o = rd_row[RW-1 -: 2];
    assign rd_addr_o = rd_row[AW-1:0];
endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
    parameter int DEPTH = 64,
    parameter int AW    = 18,
    localparam int PW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          clear_i,
    input logic          rec_valid_i,
    input logic [1:0]    rec_kind_i,
    input logic          filt_mode_i,
    input logic [PW-1:0] wr_ptr_o,
    input logic          wrapped_o,
    input logic          armed_q
);
    AST_CLEAR_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (wr_ptr_o == '0) && !wrapped_o); // R9

    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped_o && !clear_i) |=> wrapped_o); // R8

    AST_WRAP_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped_o) |-> (wr_ptr_o == '0) && ($past(wr_ptr_o) == PW'(DEPTH - 1))); // R8

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (wr_ptr_o == $past(wr_ptr_o)) || (wr_ptr_o == PW'($past(wr_ptr_o) + 1))); // R4

    AST_DISARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !clear_i) |=> $stable(wr_ptr_o)); // R2

    AST_ARM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !clear_i) |=> $stable(wr_ptr_o)); // R2

    AST_RSV_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_i && rec_kind_i == 2'b11 && !clear_i) |=> $stable(wr_ptr_o)); // R3

    AST_NORMAL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !arm_i && !clear_i && rec_valid_i && rec_kind_i != 2'b11 && !filt_mode_i)
        |=> wr_ptr_o == PW'($past(wr_ptr_o) + 1)); // R4

    AST_FILTER_KEEPS_DST_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !arm_i && !clear_i && rec_valid_i && filt_mode_i &&
         (rec_kind_i == 2'b01 || rec_kind_i == 2'b10))
        |=> wr_ptr_o == PW'($past(wr_ptr_o) + 1)); // R6

    AST_FIRST_SRC_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !clear_i) ##1 (rec_valid_i && rec_kind_i == 2'b00 && !arm_i && !clear_i)
        |=> wr_ptr_o == PW'($past(wr_ptr_o) + 1)); // R7
endmodule

bind cof_trace_rec cof_trace_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .clear_i    (clear_i),
    .rec_valid_i(rec_valid_i),
    .rec_kind_i (rec_kind_i),
    .filt_mode_i(filt_mode_i),
    .wr_ptr_o   (wr_ptr_o),
    .wrapped_o  (wrapped_o),
    .armed_q    (armed_q)
);

// File: tb/tb_cof_trace_rec.sv
`timescale 1ns/1ps
module tb_cof_trace_rec;
    localparam int DEPTH = 64;
    localparam int AW    = 18;
    localparam int PW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 1'b0, clear_i = 1'b0, rec_valid_i = 1'b0, filt_mode_i = 1'b0;
    logic [1:0]    rec_kind_i = 2'b00;
    logic [AW-1:0] rec_addr_i = '0;
    logic [PW-1:0] rd_idx_i = '0;
    logic [1:0]    rd_kind_o;
    logic [AW-1:0] rd_addr_o;
    logic [PW-1:0] wr_ptr_o;
    logic          wrapped_o;

    always #2.5 clk = ~clk;

    cof_trace_rec #(.DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .clear_i(clear_i),
        .rec_valid_i(rec_valid_i), .rec_kind_i(rec_kind_i), .rec_addr_i(rec_addr_i),
        .filt_mode_i(filt_mode_i), .rd_idx_i(rd_idx_i), .rd_kind_o(rd_kind_o),
        .rd_addr_o(rd_addr_o), .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic [1:0]    m_kind [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    int            m_ptr = 0;
    bit            m_wrap = 0, m_armed = 0, m_bgv = 0;
    logic [AW-1:0] m_bga = '0;

    function automatic bit model_drops(input logic [1:0] k, input logic [AW-1:0] a, input bit f);
        // R5: repeated source under filtering; R3: reserved kind
        if (k == 2'b11) return 1'b1;
        return f && (k == 2'b00) && m_bgv && (a == m_bga);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit arm, input bit clr, input bit vld,
                        input logic [1:0] k, input logic [AW-1:0] a, input bit f,
                        input string tag);
        arm_i = arm; clear_i = clr; rec_valid_i = vld;
        rec_kind_i = k; rec_addr_i = a; filt_mode_i = f;
        @(negedge clk);
        if (clr) begin
            m_ptr = 0; m_wrap = 0; m_armed = 0; m_bgv = 0;
        end else if (arm) begin
            m_armed = 1; m_bgv = 0;
        end else if (m_armed && vld && !model_drops(k, a, f)) begin
            m_kind[m_ptr] = k; m_addr[m_ptr] = a;
            m_bgv = 1; m_bga = a;
            if (m_ptr == DEPTH - 1) m_wrap = 1;
            m_ptr = (m_ptr + 1) % DEPTH;
        end
        arm_i = 0; clear_i = 0; rec_valid_i = 0;
        check({tag, " ptr"}, int'(wr_ptr_o), m_ptr);
        check({tag, " wrapped"}, int'(wrapped_o), int'(m_wrap));
    endtask

    task automatic rec(input logic [1:0] k, input logic [AW-1:0] a, input bit f, input string tag);
        step(0, 0, 1, k, a, f, tag);
    endtask

    task automatic dump(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx_i = PW'(i);
            @(negedge clk);
            check({tag, " R10 kind"}, int'(rd_kind_o), int'(m_kind[i]));
            check({tag, " R10 addr"}, int'(rd_addr_o), int'(m_addr[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_c0f1));
        for (int i = 0; i < DEPTH; i++) begin m_kind[i] = 2'b00; m_addr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ptr", int'(wr_ptr_o), 0);
        check("R1 wrapped", int'(wrapped_o), 0);
        dump("R1");

        // R2 disarmed: records ignored
        rec(2'b01, 18'h0AAAA, 0, "R2 disarmed");
        // R2 arm cycle with valid record: dropped
        step(1, 0, 1, 2'b00, 18'h00123, 0, "R2 arm+valid");

        // R4 normal mode stores repeated sources
        base = m_ptr;
        for (int i = 0; i < 4; i++) rec(2'b00, 18'h00200, 0, "R4 normal repeat");
        check("R4 four stored", int'(wr_ptr_o), base + 4);

        // R5 filter mode drops repeated source
        base = m_ptr;
        for (int i = 0; i < 5; i++) rec(2'b00, 18'h00300, 1, "R5 loop src");
        check("R5 one stored", int'(wr_ptr_o), base + 1);
        // R6 destination and vector repeats kept
        base = m_ptr;
        for (int i = 0; i < 3; i++) rec(2'b01, 18'h00400, 1, "R6 dst repeat");
        for (int i = 0; i < 3; i++) rec(2'b10, 18'h00FFE, 1, "R6 vec repeat");
        check("R6 six stored", int'(wr_ptr_o), base + 6);
        // R5 shadow follows last stored address of any kind
        rec(2'b00, 18'h00FFE, 1, "R5 src equals last vec");
        rec(2'b00, 18'h00300, 1, "R5 src differs");

        // R7 re-arm: same source address stored again
        step(1, 0, 0, 2'b00, '0, 1, "R7 arm");
        base = m_ptr;
        rec(2'b00, 18'h00300, 1, "R7 first src");
        check("R7 first src stored", int'(wr_ptr_o), base + 1);

        // R3 reserved kind dropped
        base = m_ptr;
        rec(2'b11, 18'h01234, 0, "R3 reserved");
        check("R3 reserved no store", int'(wr_ptr_o), base);
        dump("R3/R4/R5/R6");

        // R8 random run wrapping the memory
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [1:0] k;
            logic [AW-1:0] a;
            r = int'($urandom % 8);
            k = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            a = ($urandom % 4 != 0) ? AW'(18'h01000 + ($urandom % 3)) : AW'($urandom);
            if ($urandom % 50 == 0) step(1, 0, $urandom % 2, k, a, $urandom % 2, "R8 rand arm");
            else rec(k, a, $urandom % 2, "R8 random");
        end
        check("R8 wrapped set", int'(wrapped_o), 1);
        dump("R8");

        // R9 clear
        step(0, 1, 1, 2'b01, 18'h3FFFF, 0, "R9 clear");
        check("R9 ptr zero", int'(wr_ptr_o), 0);
        check("R9 wrapped low", int'(wrapped_o), 0);
        rec(2'b01, 18'h00777, 0, "R9 disarmed after clear");
        dump("R9 contents kept");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule